// File: doc/BRIEF.md
# Three-Operand Arithmetic and Logic Unit with Stored Carry

This block is the arithmetic and logic stage of a small load-store processor. Each cycle it receives two source operands and a 3-bit operation code, and it returns a combinational result. The processor's decode stage picks the operands from its register file and writes the result back. Any pairing of operands is allowed, including the same register on both sources, because the block sees only operand values and never register indices.

The block keeps the carry and zero flags in its own registers. They change only on a rising clock edge while the execute enable is high. Add and subtract read the stored carry and replace it, so a chain of such operations performs multi-byte arithmetic. Every logic function clears the carry as a side effect. An operation such as OR of a register with itself is therefore a way to clear the carry without changing any data. The two shift codes are decoded but have no effect: they pass operand A through and leave the flags unchanged.

The operand and result path carries no handshake. The processor's sequencer presents a new operation each execute cycle and marks it with the execute enable. Back-pressure therefore does not arise: the result is valid in the same cycle as its inputs, and the flags commit on the edge that ends that cycle.

Top module: `alu3_core`

## Requirements
- R1: Operation code 0 (add) gives result = (A + B + C) mod 256, where C is the stored carry. When enabled, the carry flag takes bit 8 of that sum.
- R2: Operation code 1 (subtract) gives result = (A - B - C) mod 256, where the stored carry acts as a borrow. When enabled, the carry flag is set exactly when A < B + C.
- R3: Operation codes 2, 3 and 4 give the bitwise OR, XOR and AND of A and B. When enabled, each of them clears the carry flag.
- R4: Operation code 5 gives the bitwise inversion of A, whatever the value of B. When enabled, it clears the carry flag.
- R5: For operation codes 0 to 5 with the execute enable high, the zero flag after the edge is 1 exactly when the result was 0x00.
- R6: While the execute enable is low at a rising edge, both flags keep their values.
- R7: Operation codes 6 and 7 (shift placeholders) give result = A and leave both flags unchanged, even when enabled.
- R8: An active-low reset clears both flags.
- R9: With the same value on A and B, XOR yields 0x00 and sets the zero flag, and OR returns the value unchanged and clears the carry flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; flags update on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the flags |
| exec_en | input | 1 | Commits the flags of this operation at the next rising edge |
| op_sel | input | 3 | Operation code (0 add, 1 sub, 2 or, 3 xor, 4 and, 5 not, 6/7 shift) |
| src_a | input | 8 | First source operand |
| src_b | input | 8 | Second source operand |
| result | output | 8 | Combinational result of the selected operation |
| carry_flag | output | 1 | Stored carry/borrow flag |
| zero_flag | output | 1 | Stored zero flag |

## Verification
The critical overlap is an add or subtract that reads the stored carry while producing the carry that replaces it at the same edge. A second overlap is a logic operation that clears a carry set by the operation just before it. Both are provoked with long random back-to-back streams that mix all eight codes with a mostly-high execute enable. They are also provoked with directed carry chains such as 0xFF+0x01 followed by an add of zeros. Each result is judged before the edge against a bench model that tracks its own flags. The flags are then judged after the edge, which shows whether the old carry was consumed and the new one kept.

// File: rtl/alu3_pkg.sv
package alu3_pkg;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_OR  = 3'd2,
    OP_XOR = 3'd3,
    OP_AND = 3'd4,
    OP_NOT = 3'd5,
    OP_SHL = 3'd6,
    OP_SHR = 3'd7
  } alu_op_e;

  typedef enum logic [1:0] {
    LG_OR  = 2'd0,
    LG_XOR = 2'd1,
    LG_AND = 2'd2,
    LG_INV = 2'd3
  } logic_fn_e;

  function automatic logic op_is_arith(alu_op_e op);
    return (op == OP_ADD) || (op == OP_SUB);
  endfunction

  function automatic logic op_is_logic(alu_op_e op);
    return (op == OP_OR) || (op == OP_XOR) || (op == OP_AND) || (op == OP_NOT);
  endfunction

  function automatic logic op_is_shift(alu_op_e op);
    return (op == OP_SHL) || (op == OP_SHR);
  endfunction

endpackage

// File: rtl/alu3_arith.sv
module alu3_arith #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             flag_c,
  input  logic             do_sub,
  output logic [WIDTH-1:0] sum,
  output logic             c_out
);
  // Subtract is A + ~B + ~borrow; the raw carry out is then "no borrow".
  logic [WIDTH-1:0] b_eff;
  logic [WIDTH:0]   chain;

  assign b_eff    = do_sub ? ~b : b;
  assign chain[0] = do_sub ? ~flag_c : flag_c;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign sum[i]     = a[i] ^ b_eff[i] ^ chain[i];
    assign chain[i+1] = (a[i] & b_eff[i]) | (chain[i] & (a[i] ^ b_eff[i]));
  end

  assign c_out = do_sub ? ~chain[WIDTH] : chain[WIDTH];
endmodule

// File: rtl/alu3_logic.sv
module alu3_logic
  import alu3_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic_fn_e        fn,
  output logic [WIDTH-1:0] y
);
  always_comb begin
    unique case (fn)
      LG_OR:   y = a | b;
      LG_XOR:  y = a ^ b;
      LG_AND:  y = a & b;
      default: y = ~a;
    endcase
  end
endmodule

// File: rtl/alu3_flags.sv
module alu3_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic upd,
  input  logic c_next,
  input  logic z_next,
  output logic c_q,
  output logic z_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_q <= 1'b0;
      z_q <= 1'b0;
    end else if (upd) begin
      c_q <= c_next;
      z_q <= z_next;
    end
  end

  assert_flags_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> ($stable(c_q) && $stable(z_q)));

  assert_flags_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> (c_q == $past(c_next)) && (z_q == $past(z_next)));
endmodule

// File: rtl/alu3_core.sv
module alu3_core
  import alu3_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             exec_en,
  input  logic [2:0]       op_sel,
  input  logic [WIDTH-1:0] src_a,
  input  logic [WIDTH-1:0] src_b,
  output logic [WIDTH-1:0] result,
  output logic             carry_flag,
  output logic             zero_flag
);
  localparam logic [WIDTH-1:0] ALL_ZERO = '0;

  alu_op_e          op;
  logic_fn_e        lg_fn;
  logic [WIDTH-1:0] arith_y;
  logic [WIDTH-1:0] logic_y;
  logic             arith_c;
  logic             c_nx;
  logic             z_nx;
  logic             flag_upd;

  assign op = alu_op_e'(op_sel);

  always_comb begin
    unique case (op)
      OP_OR:   lg_fn = LG_OR;
      OP_XOR:  lg_fn = LG_XOR;
      OP_AND:  lg_fn = LG_AND;
      default: lg_fn = LG_INV;
    endcase
  end

  alu3_arith #(.WIDTH(WIDTH)) u_arith (
    .a      (src_a),
    .b      (src_b),
    .flag_c (carry_flag),
    .do_sub (op == OP_SUB),
    .sum    (arith_y),
    .c_out  (arith_c)
  );

  alu3_logic #(.WIDTH(WIDTH)) u_logic (
    .a  (src_a),
    .b  (src_b),
    .fn (lg_fn),
    .y  (logic_y)
  );

  always_comb begin
    if (op_is_arith(op))      result = arith_y;
    else if (op_is_logic(op)) result = logic_y;
    else                      result = src_a;
  end

  assign c_nx     = op_is_arith(op) ? arith_c : 1'b0;
  assign z_nx     = (result == ALL_ZERO);
  assign flag_upd = exec_en && !op_is_shift(op);

  alu3_flags u_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .upd    (flag_upd),
    .c_next (c_nx),
    .z_next (z_nx),
    .c_q    (carry_flag),
    .z_q    (zero_flag)
  );

  assert_logic_clears_carry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_en && (op_sel inside {3'd2, 3'd3, 3'd4, 3'd5})) |=> !carry_flag);

  assert_not_ignores_b_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == 3'd5) |-> (result == ~src_a));

  assert_zero_tracks_result_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_en && !op_sel[2]) |=> (zero_flag == ($past(result) == ALL_ZERO)));

  assert_shift_is_noop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel[2:1] == 2'b11) |=> ($stable(carry_flag) && $stable(zero_flag)));

  assert_shift_passes_a_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel[2:1] == 2'b11) |-> (result == src_a));

  assert_add_sum_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_en && op_sel == 3'd0) |=>
      ({carry_flag, $past(result)} ==
       ({1'b0, $past(src_a)} + {1'b0, $past(src_b)} + {{WIDTH{1'b0}}, $past(carry_flag)})));
endmodule

// File: tb/tb_alu3_core.sv
module tb_alu3_core;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       exec_en = 1'b0;
  logic [2:0] op_sel = 3'd0;
  logic [7:0] src_a = 8'd0;
  logic [7:0] src_b = 8'd0;
  logic [7:0] result;
  logic       carry_flag;
  logic       zero_flag;

  int n_checks = 0;
  int n_fail   = 0;
  logic mc = 1'b0;
  logic mz = 1'b0;

  always #2 clk = ~clk;

  alu3_core dut (
    .clk(clk), .rst_n(rst_n), .exec_en(exec_en), .op_sel(op_sel),
    .src_a(src_a), .src_b(src_b), .result(result),
    .carry_flag(carry_flag), .zero_flag(zero_flag)
  );

  // returns {carry_out, result}
  function automatic logic [8:0] model(logic [2:0] op, logic [7:0] a, logic [7:0] b, logic c);
    logic [8:0] t;
    case (op)
      3'd0: t = {1'b0, a} + {1'b0, b} + {8'd0, c};
      3'd1: begin
        t[7:0] = a - b - {7'd0, c};
        t[8]   = ({1'b0, a} < ({1'b0, b} + {8'd0, c}));
      end
      3'd2: t = {1'b0, a | b};
      3'd3: t = {1'b0, a ^ b};
      3'd4: t = {1'b0, a & b};
      3'd5: t = {1'b0, ~a};
      default: t = {c, a};
    endcase
    return t;
  endfunction

  function automatic string op_tag(logic [2:0] op);
    case (op)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd5: return "R4";
      3'd6, 3'd7: return "R7";
      default: return "R3";
    endcase
  endfunction

  task automatic check(string tag, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // drive at negedge, judge result mid-cycle, judge flags after the edge
  task automatic run_op(logic [2:0] op, logic [7:0] a, logic [7:0] b, logic en, string tag);
    logic [8:0] e;
    @(negedge clk);
    op_sel = op; src_a = a; src_b = b; exec_en = en;
    e = model(op, a, b, mc);
    #1;
    check({tag, " result"}, int'(result), int'(e[7:0]));
    @(posedge clk);
    if (en && op < 3'd6) begin
      mc = e[8];
      mz = (e[7:0] == 8'd0);
    end
    #1;
    check(en ? {tag, " carry"} : "R6 carry hold", int'(carry_flag), int'(mc));
    check(en ? "R5 zero"       : "R6 zero hold",  int'(zero_flag),  int'(mz));
  endtask

  initial begin
    #(4 * 190000);
    n_fail++;
    n_checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    int seed_v;
    seed_v = $urandom(32'h5EED_0A17);
    repeat (3) @(posedge clk);
    #1;
    check("R8 carry reset", int'(carry_flag), 0);
    check("R8 zero reset",  int'(zero_flag),  0);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 carry chain: 0xFF+0x01 -> 0x00 with carry, then 0+0+1 -> 1
    run_op(3'd0, 8'hFF, 8'h01, 1'b1, "R1");
    run_op(3'd0, 8'h00, 8'h00, 1'b1, "R1");
    // R2 borrow: 0 - 1 -> 0xFF with borrow, then 5-2-1 -> 2
    run_op(3'd1, 8'h00, 8'h01, 1'b1, "R2");
    run_op(3'd1, 8'h05, 8'h02, 1'b1, "R2");
    // set carry, then logic clears it (R3, R4)
    run_op(3'd0, 8'h80, 8'h80, 1'b1, "R1");
    run_op(3'd3, 8'h5A, 8'h5A, 1'b1, "R9 xor same");
    run_op(3'd0, 8'hF0, 8'h20, 1'b1, "R1");
    run_op(3'd2, 8'h3C, 8'h3C, 1'b1, "R9 or same");
    run_op(3'd0, 8'hF0, 8'h20, 1'b1, "R1");
    run_op(3'd5, 8'h0F, 8'hAA, 1'b1, "R4");
    run_op(3'd5, 8'hFF, 8'h00, 1'b1, "R4");
    run_op(3'd4, 8'hC3, 8'h3C, 1'b1, "R3");
    // R6 enable low: flags keep even with carry-setting inputs
    run_op(3'd0, 8'hFF, 8'hFF, 1'b0, "R6");
    run_op(3'd0, 8'hFF, 8'hFF, 1'b1, "R1");
    run_op(3'd3, 8'h11, 8'h11, 1'b0, "R6");
    // R7 shift placeholders keep carry set
    run_op(3'd6, 8'h00, 8'h77, 1'b1, "R7");
    run_op(3'd7, 8'h9C, 8'h01, 1'b1, "R7");

    for (int i = 0; i < 3000; i++) begin
      logic [2:0] op;
      logic [7:0] a;
      logic [7:0] b;
      logic en;
      op = 3'($urandom);
      a  = 8'($urandom);
      b  = ($urandom % 8 == 0) ? a : 8'($urandom);
      en = ($urandom % 5) != 0;
      run_op(op, a, b, en, op_tag(op));
    end

    // R8 reset mid-run clears set flags
    run_op(3'd0, 8'hFF, 8'h01, 1'b1, "R1");
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    mc = 1'b0; mz = 1'b0;
    check("R8 carry async reset", int'(carry_flag), 0);
    check("R8 zero async reset",  int'(zero_flag),  0);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule